// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single line that rests high. A byte is handed over through a valid/ready handshake. The transmitter then sends a low start bit. It follows with 5 to 8 data bits, least significant bit first. An optional parity bit comes next, and the frame ends with 1, 1.5 or 2 high stop bits. The frame shape comes from an 8-bit line-control word, which the block captures at the moment a byte is accepted.

Bit timing comes from an enable that pulses at sixteen times the base bit rate. A prescaler divides this enable by a 16-bit divisor to give oversample ticks. One bit lasts sixteen oversample ticks, and half a bit lasts eight. A break control in the line-control word pulls the line low at once. It also aborts any frame in progress. When break is released, the line returns to idle and the transmitter is ready again.

Top module: `serial_tx_framer`

## Requirements
- R1: After reset, and whenever the transmitter is idle with break clear, `txd` is 1 and `in_ready` is 1.
- R2: `line_ctrl[1:0]` selects the data width: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. A frame starts with one low bit, and the selected low bits of `in_data` follow, least significant first.
- R3: When `line_ctrl[2]` is 0, the stop level lasts 16 oversample ticks. When it is 1, the stop level lasts 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words. The stop level is high.
- R4: `line_ctrl[5:3]` selects parity. Code 1 gives odd parity over the sent data bits, and code 3 gives even parity. Code 5 sends a constant 0 and code 7 a constant 1. Codes 0, 2, 4 and 6 send no parity bit.
- R5: One bit lasts 16 oversample ticks. An oversample tick is one out of every `baud_div` cycles in which `os_tick_en` is 1, and a divisor of 0 acts as 1. Cycles with `os_tick_en` at 0 do not advance the frame.
- R6: `in_ready` falls in the cycle after a byte is accepted and stays low until the last stop tick ends. It returns high in the cycle after that.
- R7: `line_ctrl` bits 5:0 are sampled when a byte is accepted. Changing them during a frame has no effect on that frame.
- R8: While `line_ctrl[6]` is 1, `txd` is 0 and `in_ready` is 0 in the same cycle, and no byte is accepted.
- R9: When `line_ctrl[6]` returns to 0, `txd` goes high and `in_ready` goes high at once. Any frame that was interrupted is dropped, and the next byte is sent as a complete new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick_en | input | 1 | Enable at 16x the base bit rate |
| line_ctrl | input | 8 | Frame format and break control |
| baud_div | input | 16 | Divisor applied to the oversample enable |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial line, idle high |

## Verification
The bench sweeps every combination of the six format bits with two data bytes. One byte has an even count of ones in its low five bits and the other an odd count. This exposes swapped odd and even parity, wrong data width and wrong stop length cycle by cycle. Further frames use divisors 3 and 0 to separate bit-length scaling from the degenerate divisor. One frame holds the enable low for a while to confirm that time stands still without it. Other cases rewrite the format mid-frame, to show it was captured at acceptance, and apply break mid-frame to confirm the abort and the clean restart.

// File: rtl/serial_tx_framer.sv
module serial_tx_framer #(
  parameter int DIV_W   = 16,
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick_en,
  input  logic [7:0]        line_ctrl,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd
);
  localparam int HALF  = OS_RATE / 2;
  localparam int OS_W  = $clog2(2 * OS_RATE + 1);
  localparam int IDX_W = $clog2(DATA_W);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t              st;
  logic [DIV_W-1:0] pre_cnt;
  logic [OS_W-1:0]  os_cnt;
  logic [IDX_W-1:0] bit_idx, f_last;
  logic [DATA_W-1:0] shreg;
  logic             f_par_en, f_par_bit, line_q;
  logic [OS_W-1:0]  f_stop_len;

  logic              brk, accept, pre_hit, os_tick, seg_done;
  logic [DIV_W-1:0]  div_eff;
  logic [OS_W-1:0]   seg_len;
  logic [DATA_W-1:0] masked;
  logic [2:0]        par_code;
  logic              par_new;
  logic [OS_W-1:0]   stop_new;

  assign brk      = line_ctrl[6];
  assign in_ready = (st == S_IDLE) && !brk;
  assign txd      = !brk && line_q;
  assign accept   = in_valid && in_ready;
  assign div_eff  = (baud_div == '0) ? DIV_W'(1) : baud_div;
  assign pre_hit  = pre_cnt >= div_eff - DIV_W'(1);
  assign os_tick  = (st != S_IDLE) && os_tick_en && pre_hit;
  assign seg_len  = (st == S_STOP) ? f_stop_len : OS_W'(OS_RATE);
  assign seg_done = os_tick && (os_cnt == seg_len - OS_W'(1));
  assign par_code = line_ctrl[5:3];

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      masked[i] = in_data[i] && (i < 5 + int'(line_ctrl[1:0]));
    case (par_code)
      3'd1:    par_new = ~^masked;
      3'd3:    par_new = ^masked;
      3'd7:    par_new = 1'b1;
      default: par_new = 1'b0;
    endcase
    if (!line_ctrl[2])            stop_new = OS_W'(OS_RATE);
    else if (line_ctrl[1:0] == 0) stop_new = OS_W'(OS_RATE + HALF);
    else                          stop_new = OS_W'(2 * OS_RATE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pre_cnt    <= '0;
      os_cnt     <= '0;
      bit_idx    <= '0;
      f_last     <= '0;
      shreg      <= '0;
      f_par_en   <= 1'b0;
      f_par_bit  <= 1'b0;
      f_stop_len <= OS_W'(OS_RATE);
      line_q     <= 1'b1;
    end else if (brk) begin
      st      <= S_IDLE;
      pre_cnt <= '0;
      os_cnt  <= '0;
      line_q  <= 1'b1;
    end else if (accept) begin
      st         <= S_START;
      pre_cnt    <= '0;
      os_cnt     <= '0;
      bit_idx    <= '0;
      f_last     <= IDX_W'(4 + int'(line_ctrl[1:0]));
      shreg      <= masked;
      f_par_en   <= par_code[0];
      f_par_bit  <= par_new;
      f_stop_len <= stop_new;
      line_q     <= 1'b0;
    end else if (st != S_IDLE && os_tick_en) begin
      pre_cnt <= pre_hit ? '0 : pre_cnt + DIV_W'(1);
      if (os_tick) begin
        if (!seg_done) begin
          os_cnt <= os_cnt + OS_W'(1);
        end else begin
          os_cnt <= '0;
          case (st)
            S_START: begin
              st     <= S_DATA;
              line_q <= shreg[0];
              shreg  <= shreg >> 1;
            end
            S_DATA: begin
              if (bit_idx == f_last) begin
                st     <= f_par_en ? S_PAR : S_STOP;
                line_q <= f_par_en ? f_par_bit : 1'b1;
              end else begin
                bit_idx <= bit_idx + IDX_W'(1);
                line_q  <= shreg[0];
                shreg   <= shreg >> 1;
              end
            end
            S_PAR: begin
              st     <= S_STOP;
              line_q <= 1'b1;
            end
            default: begin
              st     <= S_IDLE;
              line_q <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/serial_tx_framer_chk.sv
module serial_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] line_ctrl,
  input logic       in_valid,
  input logic       in_ready,
  input logic       txd
);
  a_r1_ready_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> txd);
  a_r8_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    line_ctrl[6] |-> (!txd && !in_ready));
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !txd);
  a_r9_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(line_ctrl[6]) && $past(rst_n)) |-> (txd && in_ready));
endmodule

bind serial_tx_framer serial_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_ctrl(line_ctrl),
  .in_valid(in_valid), .in_ready(in_ready), .txd(txd)
);

// File: tb/sim_serial_tx_framer.sv
`timescale 1ns/1ps
module sim_serial_tx_framer;
  logic clk = 0, rst_n = 0, os_tick_en = 1, in_valid = 0;
  logic [7:0] line_ctrl = 0, in_data = 0;
  logic [15:0] baud_div = 1;
  logic in_ready, txd;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  serial_tx_framer u0 (.clk(clk), .rst_n(rst_n), .os_tick_en(os_tick_en),
    .line_ctrl(line_ctrl), .baud_div(baud_div), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .txd(txd));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_bit(int c, int d, int n, int pe, bit pb, logic [7:0] dat);
    int os, k;
    os = c / d;
    if (os < 16) return 1'b0;
    k = (os - 16) / 16;
    if (k < n) return dat[k];
    if (pe != 0 && k == n) return pb;
    return 1'b1;
  endfunction

  task automatic frame(input logic [7:0] lc, input logic [7:0] dat, input logic [15:0] dv,
                       input int freeze, input bit alter, input string req);
    int d, n, pe, ones, stop, total, bad_c;
    bit pb, bad, ex;
    bad = 0; bad_c = 0; ex = 0;
    d = (dv == 0) ? 1 : int'(dv);
    n = 5 + lc[1:0];
    pe = lc[3];
    ones = 0;
    for (int i = 0; i < n; i++) ones += dat[i];
    case (lc[5:3])
      3'd1: pb = (ones % 2) == 0;
      3'd3: pb = (ones % 2) == 1;
      3'd7: pb = 1'b1;
      default: pb = 1'b0;
    endcase
    stop = !lc[2] ? 16 : (lc[1:0] == 0 ? 24 : 32);
    total = d * (16 * (1 + n + pe) + stop);
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", in_ready, 1);
    line_ctrl = lc; baud_div = dv; in_data = dat; in_valid = 1;
    if (freeze > 0) os_tick_en = 0;
    @(negedge clk);
    in_valid = 0;
    if (alter) line_ctrl = lc ^ 8'h3F;
    for (int i = 0; i < freeze; i++) begin
      if (txd !== 1'b0 || in_ready !== 1'b0) begin bad = 1; bad_c = i; end
      @(negedge clk);
    end
    if (freeze > 0) begin
      chk(!bad, "R5 frozen without enable", bad_c, 0);
      os_tick_en = 1;
      bad = 0;
    end
    for (int c = 0; c < total; c++) begin
      ex = exp_bit(c, d, n, pe, pb, dat);
      if (!bad && (txd !== ex || in_ready !== 1'b0)) begin
        bad = 1; bad_c = c;
        $display("  lc=%02h dat=%02h div=%0d cycle %0d txd=%b exp=%b ready=%b",
                 lc, dat, dv, c, txd, ex, in_ready);
      end
      @(negedge clk);
    end
    chk(!bad, req, bad_c, -1);
    chk(in_ready === 1'b1 && txd === 1'b1, "R6 ready after stop", {in_ready, txd}, 3);
    line_ctrl = lc;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && in_ready === 1'b1, "R1 in reset", {txd, in_ready}, 3);
    rst_n = 1;
    @(negedge clk);
    chk(txd === 1'b1 && in_ready === 1'b1, "R1 after reset", {txd, in_ready}, 3);

    // R2 R3 R4 sweep of all format codes
    for (int lc = 0; lc < 64; lc++) begin
      frame(8'(lc), 8'hA5, 16'd1, 0, 0, "R2 R3 R4 sweep");
      frame(8'(lc), 8'h3C, 16'd1, 0, 0, "R2 R3 R4 sweep");
    end
    // R5 divisor scaling and zero divisor
    for (int lc = 0; lc < 8; lc++)
      frame(8'(lc) | 8'h08, 8'hC9, 16'd3, 0, 0, "R5 divisor 3");
    frame(8'h0F, 8'h96, 16'd0, 0, 0, "R5 divisor 0 as 1");
    frame(8'h1B, 8'h5A, 16'd2, 37, 0, "R5 after freeze");
    // R7 format held through frame
    frame(8'h1F, 8'h81, 16'd1, 0, 1, "R7 format captured");
    frame(8'h00, 8'h1E, 16'd1, 0, 1, "R7 format captured");

    // R8 R9 break mid-frame
    @(negedge clk);
    line_ctrl = 8'h03; baud_div = 1; in_data = 8'hFF; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    repeat (40) @(negedge clk);
    chk(txd === 1'b1, "R2 data bit before break", txd, 1);
    line_ctrl = 8'h43; in_valid = 1; #1;
    chk(txd === 1'b0 && in_ready === 1'b0, "R8 break immediate", {txd, in_ready}, 0);
    begin
      bit bad = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (txd !== 1'b0 || in_ready !== 1'b0) bad = 1;
      end
      chk(!bad, "R8 break held", bad, 0);
    end
    in_valid = 0;
    line_ctrl = 8'h03; #1;
    chk(txd === 1'b1 && in_ready === 1'b1, "R9 release idle", {txd, in_ready}, 3);
    frame(8'h03, 8'h6D, 16'd1, 0, 0, "R9 clean frame after break");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule